// File: doc/BRIEF.md
# Input Capture Transition Counter Channel

One timer channel that watches a single input pin and records when its edges arrive. The pin passes through a synchronizer, and the selected edges (rising, falling or both) are counted down from a programmed number. When the count runs out, that is a capture event. The value of a free-running 16-bit timebase is then stored in a capture register.

Each capture event sets an interrupt flag. It can also do two more things. It can pulse a 16-bit link vector that covers a run of consecutive sibling channels. It can pulse a request to increment one flag byte in a shared parameter memory. The channel runs in one of two modes. In continuous mode it reloads the count and keeps capturing. In single mode it stops after one event and stays stopped until the CPU arms it again.

A small register port lets the CPU configure the channel and read it back. Reads are combinational and selected by address. Writes take effect on the clock edge.

Top module: `ict_channel`

## Requirements
- R1: The pin passes through two flip-flops and then an edge detector. Field CTRL[1:0] picks the edges that count: 0 none, 1 rising, 2 falling, 3 both. A pin change set up before clock edge k produces a capture event registered at edge k+2.
- R2: On a capture event, the capture register (address 4) takes the timebase value present at the clock edge that registers the event.
- R3: MAX (address 1, bits [7:0]) sets how many qualifying edges make one event, and a value of 0 acts as 1. REMAIN (address 5) reads the number of edges still needed. REMAIN drops by one on each qualifying edge.
- R4: In continuous mode (CTRL[2]=0), REMAIN reloads from MAX when an event occurs.
- R5: In single mode (CTRL[2]=1), an event sets the stopped bit (CTRL read bit 6) and clears REMAIN to 0. Edges are then ignored until a CTRL write with bit 5 set. That write reloads REMAIN and clears the stopped bit.
- R6: irq_o follows an interrupt flag. An event sets the flag. Writing 1 to STATUS bit 0 (address 6) clears it. Writing 0 there leaves it set. If an event and a clear arrive in the same cycle, the event wins.
- R7: When CTRL[3]=1, link_o pulses for exactly one cycle after an event. The pulse sets bits start .. start+count-1 modulo 16. LINK (address 2) holds start in bits [3:0] and count-1 in bits [6:4], so the count runs from 1 to 8. When CTRL[3]=0, link_o stays at 0.
- R8: When CTRL[4]=1, flag_inc_o pulses for one cycle after an event. During that pulse, flag_addr_o carries FLAGADDR (address 3, bits [7:0]). When CTRL[4]=0, flag_inc_o stays at 0.
- R9: After reset the outputs are idle. The channel is stopped, so CTRL reads 0x0040, and REMAIN reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous input pin |
| tbase_i | input | 16 | Free-running timebase |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |
| link_o | output | 16 | One-cycle link pulse to sibling channels |
| flag_inc_o | output | 1 | One-cycle flag byte increment request |
| flag_addr_o | output | 8 | Parameter memory address of the flag byte |

## Verification
A wrong remaining count shows up as events arriving one edge early or late. The count itself can be read back through REMAIN right after the last edge of a burst. A stuck stopped bit appears at once in CTRL bit 6, and also as missing interrupt and link pulses on the next qualifying edge. Capture timing is checked by changing the timebase on every cycle around an edge. A capture taken one register stage off therefore returns a different value. The wrap of the link window is checked with a start channel near the top of the range.

// File: rtl/ict_pkg.sv
package ict_pkg;
  localparam int REG_W = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_MAX    = 3'd1,
    A_LINK   = 3'd2,
    A_FLAG   = 3'd3,
    A_CAP    = 3'd4,
    A_REMAIN = 3'd5,
    A_STATUS = 3'd6
  } reg_addr_e;

  // CTRL bit positions
  localparam int C_SINGLE = 2;
  localparam int C_LINK   = 3;
  localparam int C_FLAG   = 4;
  localparam int C_ARM    = 5;
  localparam int C_STOP   = 6;
endpackage

// File: rtl/ict_edge_sync.sv
module ict_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] sel_i,
  output logic       hit_o
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;
  logic                   cur;

  assign cur = chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i};
      prev_q  <= cur;
    end
  end

  assign hit_o = (sel_i[0] & cur & ~prev_q) | (sel_i[1] & ~cur & prev_q);
endmodule

// File: rtl/ict_event_counter.sv
module ict_event_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             hit_i,
  input  logic             single_i,
  input  logic [CNT_W-1:0] max_i,
  output logic             evt_o,
  output logic [CNT_W-1:0] remain_o,
  output logic             stopped_o
);
  logic [CNT_W-1:0] eff_max;
  logic [CNT_W-1:0] remain_q;
  logic             stopped_q;

  assign eff_max   = (max_i == '0) ? CNT_W'(1) : max_i;
  assign evt_o     = hit_i && !stopped_q && !arm_i && (remain_q <= CNT_W'(1));
  assign remain_o  = remain_q;
  assign stopped_o = stopped_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q  <= '0;
      stopped_q <= 1'b1;
    end else if (arm_i) begin
      remain_q  <= eff_max;
      stopped_q <= 1'b0;
    end else if (evt_o) begin
      remain_q  <= single_i ? '0 : eff_max;
      stopped_q <= single_i;
    end else if (hit_i && !stopped_q) begin
      remain_q  <= remain_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/ict_link_decode.sv
module ict_link_decode #(
  parameter int NUM_CH   = 16,
  parameter int LINK_MAX = 8,
  localparam int SW = $clog2(NUM_CH),
  localparam int CW = $clog2(LINK_MAX)
) (
  input  logic          en_i,
  input  logic [SW-1:0] start_i,
  input  logic [CW-1:0] cnt_m1_i,
  output logic [NUM_CH-1:0] vec_o
);
  // offset wraps modulo NUM_CH (power of two)
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [SW-1:0] off;
    assign off      = SW'(g) - start_i;
    assign vec_o[g] = en_i && (off <= SW'(cnt_m1_i));
  end
endmodule

// File: rtl/ict_channel.sv
module ict_channel
  import ict_pkg::*;
#(
  parameter int TB_W        = 16,
  parameter int CNT_W       = 8,
  parameter int NUM_CH      = 16,
  parameter int LINK_MAX    = 8,
  parameter int FLAG_AW     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pin_i,
  input  logic [TB_W-1:0]    tbase_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               irq_o,
  output logic [NUM_CH-1:0]  link_o,
  output logic               flag_inc_o,
  output logic [FLAG_AW-1:0] flag_addr_o
);
  localparam int SW = $clog2(NUM_CH);
  localparam int CW = $clog2(LINK_MAX);

  logic [1:0]         edge_sel_q;
  logic               single_q, link_en_q, flag_en_q;
  logic [CNT_W-1:0]   max_q;
  logic [SW-1:0]      link_start_q;
  logic [CW-1:0]      link_cnt_q;
  logic [FLAG_AW-1:0] flag_addr_q;
  logic [TB_W-1:0]    cap_q;
  logic               irq_q;
  logic [NUM_CH-1:0]  link_q;
  logic               flag_inc_q;

  logic               hit, evt, stopped, arm_wr, wr_ctrl;
  logic [CNT_W-1:0]   remain;
  logic [NUM_CH-1:0]  link_vec;

  assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
  assign arm_wr  = wr_ctrl && reg_wdata_i[C_ARM];

  ict_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i, .sel_i(edge_sel_q), .hit_o(hit)
  );

  ict_event_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .arm_i(arm_wr), .hit_i(hit), .single_i(single_q),
    .max_i(max_q), .evt_o(evt), .remain_o(remain), .stopped_o(stopped)
  );

  ict_link_decode #(.NUM_CH(NUM_CH), .LINK_MAX(LINK_MAX)) u_link (
    .en_i(link_en_q), .start_i(link_start_q), .cnt_m1_i(link_cnt_q), .vec_o(link_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_sel_q   <= '0;
      single_q     <= 1'b0;
      link_en_q    <= 1'b0;
      flag_en_q    <= 1'b0;
      max_q        <= CNT_W'(1);
      link_start_q <= '0;
      link_cnt_q   <= '0;
      flag_addr_q  <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_CTRL: begin
          edge_sel_q <= reg_wdata_i[1:0];
          single_q   <= reg_wdata_i[C_SINGLE];
          link_en_q  <= reg_wdata_i[C_LINK];
          flag_en_q  <= reg_wdata_i[C_FLAG];
        end
        A_MAX:  max_q <= reg_wdata_i[CNT_W-1:0];
        A_LINK: begin
          link_start_q <= reg_wdata_i[SW-1:0];
          link_cnt_q   <= reg_wdata_i[4 +: CW];
        end
        A_FLAG: flag_addr_q <= reg_wdata_i[FLAG_AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q      <= '0;
      irq_q      <= 1'b0;
      link_q     <= '0;
      flag_inc_q <= 1'b0;
    end else begin
      link_q     <= evt ? link_vec : '0;
      flag_inc_q <= evt && flag_en_q;
      if (evt) cap_q <= tbase_i;
      if (evt) irq_q <= 1'b1;
      else if (reg_we_i && reg_addr_i == A_STATUS && reg_wdata_i[0]) irq_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[1:0]      = edge_sel_q;
        reg_rdata_o[C_SINGLE] = single_q;
        reg_rdata_o[C_LINK]   = link_en_q;
        reg_rdata_o[C_FLAG]   = flag_en_q;
        reg_rdata_o[C_STOP]   = stopped;
      end
      A_MAX:    reg_rdata_o[CNT_W-1:0] = max_q;
      A_LINK:   begin
        reg_rdata_o[SW-1:0] = link_start_q;
        reg_rdata_o[4 +: CW] = link_cnt_q;
      end
      A_FLAG:   reg_rdata_o[FLAG_AW-1:0] = flag_addr_q;
      A_CAP:    reg_rdata_o[TB_W-1:0] = cap_q;
      A_REMAIN: reg_rdata_o[CNT_W-1:0] = remain;
      A_STATUS: reg_rdata_o[0] = irq_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o       = irq_q;
  assign link_o      = link_q;
  assign flag_inc_o  = flag_inc_q;
  assign flag_addr_o = flag_addr_q;
endmodule

// File: rtl/ict_channel_chk.sv
module ict_channel_chk #(
  parameter int TB_W   = 16,
  parameter int NUM_CH = 16,
  parameter int CW     = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt,
  input logic              stopped,
  input logic              single_q,
  input logic [TB_W-1:0]   tbase_i,
  input logic [TB_W-1:0]   cap_q,
  input logic              irq_o,
  input logic [NUM_CH-1:0] link_o,
  input logic [CW-1:0]     link_cnt_q,
  input logic              flag_inc_o
);
  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> cap_q == $past(tbase_i));

  p_single_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && single_q) |=> stopped);

  p_irq_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> irq_o);

  p_link_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_o != '0) |-> ($countones(link_o) == int'($past(link_cnt_q)) + 1));

  p_flag_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_inc_o |-> $past(evt));
endmodule

bind ict_channel ict_channel_chk #(.TB_W(TB_W), .NUM_CH(NUM_CH), .CW($clog2(LINK_MAX))) u_chk (
  .clk_i, .rst_ni, .evt, .stopped, .single_q, .tbase_i, .cap_q,
  .irq_o, .link_o, .link_cnt_q, .flag_inc_o
);

// File: tb/ict_channel_bench.sv
module ict_channel_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [15:0] tbase = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic [15:0] link;
  logic        finc;
  logic [7:0]  faddr;

  int n_chk = 0, n_fail = 0;
  int link_pulses = 0, flag_pulses = 0;
  logic [15:0] last_link = '0;
  logic [7:0]  last_faddr = '0;

  always #(CLK_P/2) clk = ~clk;

  ict_channel u_ict_channel (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .tbase_i(tbase),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .link_o(link), .flag_inc_o(finc), .flag_addr_o(faddr)
  );

  always @(negedge clk) begin
    if (link != '0) begin link_pulses++; last_link = link; end
    if (finc) begin flag_pulses++; last_faddr = faddr; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic toggle(input int n);
    for (int i = 0; i < n; i++) begin
      pin = ~pin;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic prep();
    wr(3'd0, 16'h0000);
    pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  typedef struct packed {
    logic [1:0]  sel;
    logic [7:0]  max;
    logic [3:0]  toggles;
    logic [3:0]  evts;
    logic [7:0]  remain;
    logic [15:0] tb;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd1, 8'd1, 4'd6, 4'd3, 8'd1, 16'hA001},
    '{2'd2, 8'd1, 4'd6, 4'd3, 8'd1, 16'hA002},
    '{2'd3, 8'd2, 4'd5, 4'd2, 8'd1, 16'hA003},
    '{2'd3, 8'd3, 4'd7, 4'd2, 8'd2, 16'hA004},
    '{2'd1, 8'd0, 4'd4, 4'd2, 8'd1, 16'hA005},
    '{2'd0, 8'd1, 4'd4, 4'd0, 8'd1, 16'hA006}
  };

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [15:0] d;
    int bl, bf;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 irq", irq, 0);
    chk("R9 link", link, 0);
    chk("R9 flag_inc", finc, 0);
    rd(3'd0, d); chk("R9 ctrl", d, 16'h0040);
    rd(3'd5, d); chk("R9 remain", d, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table: continuous mode, link+flag enabled
    foreach (VECS[v]) begin
      prep();
      wr(3'd1, {8'h00, VECS[v].max});
      wr(3'd2, 16'h0073);
      wr(3'd3, 16'h005A);
      tbase = VECS[v].tb;
      wr(3'd0, 16'h0038 | {14'd0, VECS[v].sel});
      bl = link_pulses;
      toggle(int'(VECS[v].toggles));
      repeat (2) @(negedge clk);
      chk("R1 R3 R4 event count", link_pulses - bl, VECS[v].evts);
      rd(3'd5, d); chk("R3 R4 remain", d, VECS[v].remain);
      if (VECS[v].evts != 0) begin
        rd(3'd4, d); chk("R2 capture", d, VECS[v].tb);
      end
      if (v == 0) chk("R7 link start3 cnt8", last_link, 16'h07F8);
    end

    // R2 R7 R8 exact timing, link wrap
    prep();
    wr(3'd1, 16'd1);
    wr(3'd2, 16'h002E);
    wr(3'd3, 16'h00C3);
    wr(3'd0, 16'h0039);
    wr(3'd6, 16'h0001);
    @(negedge clk); pin = 1'b1; tbase = 16'h1111;
    @(negedge clk); tbase = 16'h2222;
    @(negedge clk); tbase = 16'h3333;
    @(negedge clk); tbase = 16'h4444;
    rd(3'd4, d); chk("R2 capture edge timing", d, 16'h3333);
    chk("R1 R6 irq after edge", irq, 1);
    chk("R7 link wrap", link, 16'hC001);
    chk("R8 flag_inc", finc, 1);
    chk("R8 flag_addr", faddr, 8'hC3);
    @(negedge clk);
    chk("R7 link one cycle", link, 0);
    chk("R8 flag one cycle", finc, 0);

    // R6 clear behaviour
    wr(3'd6, 16'h0000); chk("R6 write0 keeps", irq, 1);
    wr(3'd6, 16'h0001); chk("R6 write1 clears", irq, 0);

    // R7 R8 disabled
    prep();
    wr(3'd0, 16'h0021);
    bl = link_pulses; bf = flag_pulses;
    toggle(1);
    chk("R6 irq without link", irq, 1);
    chk("R7 link disabled", link_pulses - bl, 0);
    chk("R8 flag disabled", flag_pulses - bf, 0);

    // R5 single mode
    prep();
    wr(3'd1, 16'd2);
    wr(3'd0, 16'h003D);
    bl = link_pulses;
    toggle(6);
    repeat (2) @(negedge clk);
    chk("R5 single one event", link_pulses - bl, 1);
    rd(3'd5, d); chk("R5 remain zero", d, 0);
    rd(3'd0, d); chk("R5 stopped bit", d[6], 1);
    wr(3'd0, 16'h003D);
    rd(3'd5, d); chk("R5 rearm reload", d, 2);
    rd(3'd0, d); chk("R5 rearm running", d[6], 0);

    report();
  end
endmodule